// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Byte Lanes

This block connects a clocked on-chip requester to an external asynchronous static RAM of 128K words by 16 bits. The requester presents one access at a time through a valid/ready handshake: a 17-bit word address, a read/write flag, 16 bits of write data and a 2-bit byte mask. Reads return their data on `rd_data` together with a single-cycle `rd_valid` pulse.

On the memory side the controller produces active-low chip select, write enable, output enable and two byte-lane enables. It also drives the address and a data bus that is split into an output word, a per-lane output enable and an input word. Every strobe width is a clock count. Each count is derived at elaboration by rounding the nanosecond minimum of the memory up to whole clock periods. A read that is followed by a write gets an idle turnaround window, so the memory has released the bus before the controller drives it. The controller drives only the lanes selected by the mask, and only while write enable is low.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset, `req_ready` is 1, `rd_valid` is 0, chip select, write enable, output enable and both byte enables are high (inactive), and `mem_dq_oe` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the access, with its recovery, is complete.
- R3: A write holds write enable low for WP = max(ceil(45/T), ceil(50/T), ceil(25/T)) consecutive cycles, where T is the clock period in ns. Output enable stays high throughout, and the address is stable while chip select is low.
- R4: Chip select stays low for at least ceil(55/T) cycles for every write, counting the write-enable-low phase plus a recovery of at least one cycle with write enable high.
- R5: Mask bit 0 selects the lower lane (data bits 7:0, byte enable index 0). Mask bit 1 selects the upper lane (bits 15:8, index 1). Only selected lanes have their byte enable low and their `mem_dq_oe` bit set. A write with mask 00 changes no memory content.
- R6: A read holds output enable low and write enable high for max(ceil(55/T), ceil(30/T)) consecutive cycles. The data bus input is sampled on the final edge of that window.
- R7: `rd_valid` is a one-cycle pulse in the cycle after the last output-enable-low cycle. In `rd_data`, the lanes that are not in the mask read as zero.
- R8: No bit of `mem_dq_oe` is ever 1 unless write enable is low and output enable is high.
- R9: When a write follows a read, at least ceil(20/T) cycles with output enable high separate the last output-enable-low cycle from the first write-enable-low cycle.
- R10: Whenever chip select is high, write enable, output enable and both byte enables are high and no lane is driven. The controller returns to this standby state for at least one cycle between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lane select, bit 0 lower, bit 1 upper |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| rd_data | output | 16 | Registered read data, unselected lanes zero |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_be_n | output | 2 | Byte enables, index 0 lower lane, active low |
| mem_addr | output | 17 | Memory address |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 2 | Per-lane drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data bus as seen from the memory |

## Verification
The bench targets single-lane writes, mask-00 writes and partial-mask reads. A controller that gated lanes wrongly would corrupt the neighbouring byte in the memory model, or would return stale bits in a lane that was not requested. It also issues reads followed at once by writes, at the highest and lowest addresses. A missing turnaround would show as write enable falling within a cycle or two of output enable rising, and a short strobe count would show as a write-enable or output-enable window shorter than the rounded-up nanosecond minimum. A controller that leaks drive outside write enable, or leaves a strobe active while deselected, is flagged by a cycle-by-cycle watch of the memory pins.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TURN  = 3'd1,
    ST_WRITE = 3'd2,
    ST_WREC  = 3'd3,
    ST_READ  = 3'd4
  } seq_state_e;

  // Round a nanosecond minimum up to whole clock periods.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] wbyte,
  input  logic       sel_nxt,
  input  logic       drive_nxt,
  input  logic       capture,
  input  logic [7:0] din,
  output logic       be_n,
  output logic [7:0] dout,
  output logic       oe,
  output logic [7:0] rd_byte
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_n <= 1'b1;
      oe   <= 1'b0;
    end else begin
      be_n <= ~sel_nxt;
      oe   <= sel_nxt & drive_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (load) begin
      dout <= wbyte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_byte <= '0;
    end else if (capture) begin
      rd_byte <= be_n ? 8'h00 : din;
    end
  end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int LANES   = 2,
  parameter int CLK_NS  = 10,
  parameter int T_RD_NS = 55,
  parameter int T_OE_NS = 30,
  parameter int T_WP_NS = 45,
  parameter int T_AW_NS = 50,
  parameter int T_DW_NS = 25,
  parameter int T_WC_NS = 55,
  parameter int T_HZ_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_mask,
  output logic              req_ready,
  output logic              accept,
  output logic [LANES-1:0]  lane_sel_nxt,
  output logic              drive_nxt,
  output logic              capture,
  output logic              rd_valid,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr
);

  localparam int RD_CYC  = imax(1, imax(ns_to_cyc(T_RD_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)));
  localparam int WP_CYC  = imax(1, imax(ns_to_cyc(T_WP_NS, CLK_NS),
                                        imax(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS))));
  localparam int REC_CYC = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - WP_CYC);
  localparam int TA_CYC  = imax(1, ns_to_cyc(T_HZ_NS, CLK_NS));
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(REC_CYC, TA_CYC));
  localparam int CW      = $clog2(MAX_CYC + 1);

  localparam logic [CW-1:0] RD_LD  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LD  = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] REC_LD = CW'(REC_CYC - 1);
  localparam logic [CW-1:0] TA_LD  = CW'(TA_CYC - 1);

  seq_state_e        state_q, state_d;
  logic              ta_pend_q, ta_pend_d;
  logic              t_load;
  logic [CW-1:0]     t_val;
  logic              t_done;
  logic [LANES-1:0]  op_mask_q;
  logic [LANES-1:0]  mask_nxt;
  logic              busy_nxt;

  sram_phase_timer #(.CW(CW)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  assign req_ready = (state_q == ST_IDLE) && srst_n;
  assign accept    = req_ready && req_valid;
  assign capture   = (state_q == ST_READ) && t_done;

  // Next-state and phase timer load
  always_comb begin
    state_d   = state_q;
    ta_pend_d = ta_pend_q;
    t_load    = 1'b0;
    t_val     = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          t_load = 1'b1;
          if (!req_write) begin
            state_d = ST_READ;
            t_val   = RD_LD;
          end else if (ta_pend_q) begin
            state_d = ST_TURN;
            t_val   = TA_LD;
          end else begin
            state_d = ST_WRITE;
            t_val   = WP_LD;
          end
        end
      end
      ST_TURN: begin
        if (t_done) begin
          state_d   = ST_WRITE;
          ta_pend_d = 1'b0;
          t_load    = 1'b1;
          t_val     = WP_LD;
        end
      end
      ST_WRITE: begin
        ta_pend_d = 1'b0;
        if (t_done) begin
          state_d = ST_WREC;
          t_load  = 1'b1;
          t_val   = REC_LD;
        end
      end
      ST_WREC: begin
        if (t_done) begin
          state_d = ST_IDLE;
        end
      end
      ST_READ: begin
        if (t_done) begin
          state_d   = ST_IDLE;
          ta_pend_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    mask_nxt     = accept ? req_mask : op_mask_q;
    busy_nxt     = (state_d == ST_READ) || (state_d == ST_WRITE) || (state_d == ST_WREC);
    lane_sel_nxt = busy_nxt ? mask_nxt : '0;
    drive_nxt    = (state_d == ST_WRITE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ta_pend_q <= 1'b0;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      rd_valid  <= 1'b0;
    end else begin
      state_q   <= state_d;
      ta_pend_q <= ta_pend_d;
      mem_cs_n  <= ~busy_nxt;
      mem_we_n  <= ~(state_d == ST_WRITE);
      mem_oe_n  <= ~(state_d == ST_READ);
      rd_valid  <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_mask_q <= '0;
      mem_addr  <= '0;
    end else if (accept) begin
      op_mask_q <= req_mask;
      mem_addr  <= req_addr;
    end
  end

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 10,
  parameter int T_RD_NS = 55,
  parameter int T_OE_NS = 30,
  parameter int T_WP_NS = 45,
  parameter int T_AW_NS = 50,
  parameter int T_DW_NS = 25,
  parameter int T_WC_NS = 55,
  parameter int T_HZ_NS = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                mem_cs_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic [DATA_W/8-1:0] mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_in
);

  localparam int LANES = DATA_W / 8;

  logic             srst_n;
  logic             accept;
  logic [LANES-1:0] lane_sel_nxt;
  logic             drive_nxt;
  logic             capture;

  sram_rst_sync i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  sram_seq_fsm #(
    .ADDR_W  (ADDR_W),
    .LANES   (LANES),
    .CLK_NS  (CLK_NS),
    .T_RD_NS (T_RD_NS),
    .T_OE_NS (T_OE_NS),
    .T_WP_NS (T_WP_NS),
    .T_AW_NS (T_AW_NS),
    .T_DW_NS (T_DW_NS),
    .T_WC_NS (T_WC_NS),
    .T_HZ_NS (T_HZ_NS)
  ) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .srst_n       (srst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_mask     (req_mask),
    .req_ready    (req_ready),
    .accept       (accept),
    .lane_sel_nxt (lane_sel_nxt),
    .drive_nxt    (drive_nxt),
    .capture      (capture),
    .rd_valid     (rd_valid),
    .mem_cs_n     (mem_cs_n),
    .mem_we_n     (mem_we_n),
    .mem_oe_n     (mem_oe_n),
    .mem_addr     (mem_addr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_byte_lane i_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .wbyte     (req_wdata[g*8 +: 8]),
      .sel_nxt   (lane_sel_nxt[g]),
      .drive_nxt (drive_nxt),
      .capture   (capture),
      .din       (mem_dq_in[g*8 +: 8]),
      .be_n      (mem_be_n[g]),
      .dout      (mem_dq_out[g*8 +: 8]),
      .oe        (mem_dq_oe[g]),
      .rd_byte   (rd_data[g*8 +: 8])
    );
  end

endmodule

// File: rtl/sram_ctl_checker.sv
module sram_ctl_checker
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int LANES   = 2,
  parameter int CLK_NS  = 10,
  parameter int T_RD_NS = 55,
  parameter int T_OE_NS = 30,
  parameter int T_WP_NS = 45,
  parameter int T_AW_NS = 50,
  parameter int T_DW_NS = 25,
  parameter int T_HZ_NS = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_be_n,
  input logic [LANES-1:0]  mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);

  localparam int RD_MIN_C = imax(1, imax(ns_to_cyc(T_RD_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)));
  localparam int WP_MIN_C = imax(1, imax(ns_to_cyc(T_WP_NS, CLK_NS),
                                         imax(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS))));
  localparam int TA_MIN_C = imax(1, ns_to_cyc(T_HZ_NS, CLK_NS));
  localparam int RW       = $clog2(imax(imax(RD_MIN_C, WP_MIN_C), TA_MIN_C) + 2) + 1;
  localparam logic [RW-1:0] RD_MIN = RW'(RD_MIN_C);
  localparam logic [RW-1:0] WP_MIN = RW'(WP_MIN_C);
  localparam logic [RW-1:0] TA_MIN = RW'(TA_MIN_C);
  localparam logic [RW-1:0] SAT    = '1;

  logic [RW-1:0] we_run_q;
  logic [RW-1:0] oe_run_q;
  logic [RW-1:0] oe_gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run_q <= '0;
      oe_run_q <= '0;
      oe_gap_q <= SAT;
    end else begin
      we_run_q <= mem_we_n ? '0 : ((we_run_q == SAT) ? SAT : we_run_q + 1'b1);
      oe_run_q <= mem_oe_n ? '0 : ((oe_run_q == SAT) ? SAT : oe_run_q + 1'b1);
      oe_gap_q <= !mem_oe_n ? '0 : ((oe_gap_q == SAT) ? SAT : oe_gap_q + 1'b1);
    end
  end

  AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run_q >= WP_MIN)); // R3

  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R3

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R3

  AST_LANE_DRIVE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_dq_oe & mem_be_n) == '0)); // R5

  AST_OE_WINDOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run_q >= RD_MIN)); // R6

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R7

  AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe != '0) |-> (!mem_we_n && mem_oe_n)); // R8

  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (oe_gap_q >= TA_MIN)); // R9

  AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n); // R2

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_we_n && mem_oe_n && (&mem_be_n) && (mem_dq_oe == '0))); // R10

endmodule

bind sram_async_ctl sram_ctl_checker #(
  .ADDR_W  (ADDR_W),
  .LANES   (DATA_W / 8),
  .CLK_NS  (CLK_NS),
  .T_RD_NS (T_RD_NS),
  .T_OE_NS (T_OE_NS),
  .T_WP_NS (T_WP_NS),
  .T_AW_NS (T_AW_NS),
  .T_DW_NS (T_DW_NS),
  .T_HZ_NS (T_HZ_NS)
) i_sram_ctl_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_be_n  (mem_be_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/test_sram_async_ctl.sv
`timescale 1ns/1ps
module test_sram_async_ctl;

  localparam int PER = 4;

  function automatic int cdiv(input int ns);
    return (ns + PER - 1) / PER;
  endfunction

  // Expected strobe counts, from the requirement formulas at T = 4 ns
  localparam int WP_EXP = (cdiv(45) > cdiv(50)) ? cdiv(45) : cdiv(50);
  localparam int RD_EXP = cdiv(55);
  localparam int WC_EXP = cdiv(55);
  localparam int TA_EXP = cdiv(20);

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [16:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        mem_cs_n;
  logic        mem_we_n;
  logic        mem_oe_n;
  logic [1:0]  mem_be_n;
  logic [16:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic [1:0]  mem_dq_oe;
  logic [15:0] mem_dq_in;

  int total = 0;
  int bad   = 0;
  bit done_flag = 0;

  sram_async_ctl #(.CLK_NS(PER)) i_sram_async_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_mask   (req_mask),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_be_n   (mem_be_n),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );

  initial clk = 1'b0;
  always #(PER/2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // Behavioural byte-lane memory and bench shadow
  logic [15:0] mdl [int unsigned];
  logic [15:0] shd [int unsigned];

  function automatic logic [15:0] seed_word(input int unsigned a);
    logic [31:0] t;
    t = a * 32'h9E37;
    return t[15:0] ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] mdl_get(input int unsigned a);
    return mdl.exists(a) ? mdl[a] : seed_word(a);
  endfunction

  function automatic logic [15:0] shd_get(input int unsigned a);
    return shd.exists(a) ? shd[a] : seed_word(a);
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] m);
    logic [15:0] r;
    r = old;
    for (int l = 0; l < 2; l++) if (m[l]) r[l*8 +: 8] = nw[l*8 +: 8];
    return r;
  endfunction

  function automatic logic [15:0] lanes_only(input logic [15:0] w, input logic [1:0] m);
    logic [15:0] r;
    r = '0;
    for (int l = 0; l < 2; l++) if (m[l]) r[l*8 +: 8] = w[l*8 +: 8];
    return r;
  endfunction

  always @(negedge clk) begin
    logic [15:0] w;
    if (rst_n && !mem_cs_n && !mem_we_n) begin
      w = mdl_get(int'(mem_addr));
      for (int l = 0; l < 2; l++)
        if (!mem_be_n[l] && mem_dq_oe[l]) w[l*8 +: 8] = mem_dq_out[l*8 +: 8];
      mdl[int'(mem_addr)] = w;
    end
    w = mdl_get(int'(mem_addr));
    for (int l = 0; l < 2; l++)
      mem_dq_in[l*8 +: 8] <= (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_be_n[l]) ? w[l*8 +: 8] : 8'hA5;
  end

  // Pin monitor
  bit mon_on = 0;
  int cs_run = 0, we_len = 0, oe_len = 0, oe_gap = 1000;
  bit saw_we = 0, saw_oe = 0, prev_read = 0;
  int drive_bad = 0, standby_bad = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if ((mem_dq_oe != 2'b00) && (mem_we_n || !mem_oe_n || ((mem_dq_oe & mem_be_n) != 2'b00)))
        drive_bad++;
      if (mem_cs_n && !(mem_we_n && mem_oe_n && (&mem_be_n) && (mem_dq_oe == 2'b00)))
        standby_bad++;
      if (!mem_cs_n) begin
        cs_run++;
        if (!mem_we_n) begin
          if (!saw_we && prev_read)
            chk(oe_gap >= TA_EXP, "R9 turnaround cycles", oe_gap, TA_EXP);
          saw_we = 1;
          we_len++;
        end
        if (!mem_oe_n) begin
          saw_oe = 1;
          oe_len++;
        end
      end else if (cs_run > 0) begin
        if (saw_we) begin
          chk(we_len >= WP_EXP, "R3 write pulse cycles", we_len, WP_EXP);
          chk(cs_run >= WC_EXP, "R4 write cycle length", cs_run, WC_EXP);
        end
        if (saw_oe)
          chk(oe_len >= RD_EXP, "R6 read window cycles", oe_len, RD_EXP);
        prev_read = saw_oe;
        cs_run = 0; we_len = 0; oe_len = 0; saw_we = 0; saw_oe = 0;
      end
      if (!mem_oe_n) oe_gap = 0;
      else if (oe_gap < 1000) oe_gap++;
    end
  end

  task automatic issue(input bit wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
    int guard;
    logic [15:0] exp;
    guard = 0;
    @(negedge clk);
    while (!req_ready && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_mask  = m;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 ready low while busy", req_ready, 0);
    if (wr) begin
      shd[int'(a)] = merge(shd_get(int'(a)), d, m);
    end else begin
      exp = lanes_only(shd_get(int'(a)), m);
      guard = 0;
      while (!rd_valid && guard < 1000) begin
        @(negedge clk);
        guard++;
      end
      chk(rd_data == exp, "R7 read data lanes", rd_data, exp);
      @(negedge clk);
      chk(!rd_valid, "R7 valid one cycle", rd_valid, 0);
    end
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    @(negedge clk);
    while (!req_ready && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [16:0] pool [8];

  initial begin
    logic [15:0] w;
    logic [15:0] s;
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    chk({mem_cs_n, mem_we_n, mem_oe_n, mem_be_n} == 5'b11111, "R1 strobes",
        {mem_cs_n, mem_we_n, mem_oe_n, mem_be_n}, 5'b11111);
    chk(mem_dq_oe == 2'b00, "R1 bus released", mem_dq_oe, 0);
    mon_on = 1;

    // Full word at lowest address
    issue(1, 17'h00000, 16'h1234, 2'b11);
    issue(0, 17'h00000, 16'h0000, 2'b11);

    // R5 lower lane only at top address
    s = mdl_get(32'h1FFFF);
    issue(1, 17'h1FFFF, 16'hABCD, 2'b01);
    wait_idle();
    w = mdl_get(32'h1FFFF);
    chk(w == {s[15:8], 8'hCD}, "R5 lower lane write", w, {s[15:8], 8'hCD});

    // R5 upper lane only
    issue(1, 17'h1FFFF, 16'h5566, 2'b10);
    wait_idle();
    w = mdl_get(32'h1FFFF);
    chk(w == {8'h55, 8'hCD}, "R5 upper lane write", w, {8'h55, 8'hCD});
    issue(0, 17'h1FFFF, 16'h0000, 2'b11);

    // R5 empty mask changes nothing
    s = mdl_get(32'h5);
    issue(1, 17'h00005, 16'hFFFF, 2'b00);
    wait_idle();
    w = mdl_get(32'h5);
    chk(w == s, "R5 empty mask write", w, s);

    // R7 partial reads zero the unselected lane
    issue(0, 17'h00000, 16'h0000, 2'b01);
    issue(0, 17'h00000, 16'h0000, 2'b10);
    issue(0, 17'h00005, 16'h0000, 2'b00);

    // R9 read immediately followed by write
    issue(0, 17'h00003, 16'h0000, 2'b11);
    issue(1, 17'h00003, 16'hC0DE, 2'b11);
    issue(0, 17'h00003, 16'h0000, 2'b11);

    // Constrained random mix
    pool[0] = 17'h00000; pool[1] = 17'h00001; pool[2] = 17'h00002; pool[3] = 17'h00003;
    pool[4] = 17'h1FFFF; pool[5] = 17'h10000; pool[6] = 17'h0AAAA; pool[7] = 17'h15555;
    for (int i = 0; i < 80; i++) begin
      issue(1'($urandom % 2), pool[$urandom % 8], 16'($urandom), 2'($urandom % 4));
    end
    wait_idle();
    repeat (3) @(negedge clk);

    chk(drive_bad == 0, "R8 drive outside write", drive_bad, 0);
    chk(standby_bad == 0, "R10 standby quiet", standby_bad, 0);
    chk(req_ready == 1'b1 && mem_cs_n == 1'b1, "R10 returns to standby",
        {req_ready, mem_cs_n}, 2'b11);

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule